// File: doc/BRIEF.md
# Segment-Register Address Extender

This block widens a 16-bit logical bus address into a 20-bit physical address. It keeps two segment registers, one for code and one for data. On each bus request it takes the selected segment, moves it four bit positions up (one hex digit), adds the logical address, and drops any carry beyond the physical width. The registered result is presented one clock later, together with a valid flag.

A status input from the processor picks the segment for each request. When that input marks the cycle as an opcode fetch, the code segment is used. Every other access, including immediate operands and argument words that follow an opcode, uses the data segment.

Software loads the segments through a small write port. That port has a write strobe, a one-bit target select and a 16-bit data word. A value that is written is used from the next request onward. A request in the same clock as the write still sees the old value.

Top module: `seg_addr_ext`

## Requirements
- R1: While reset is held, and in the first cycle after it, phys_valid is 0 and phys_addr is 0. Both segments are zero after reset, so a request then returns its own logical address zero-extended.
- R2: For a request with segment S and logical address L, phys_addr equals (S*16 + L) taken modulo 2^20. For example, S=0x3120 and L=0xA000 give 0x3B200. The lowest four bits of phys_addr always equal the lowest four bits of L.
- R3: A carry out of bit 19 is discarded. For example, S=0xFFFF and L=0xFFFF give 0x0FFEF, and S=0xFFFF and L=0x0010 give 0x00000.
- R4: A request with bus_iaq=1 (opcode fetch) is translated with the code segment.
- R5: A request with bus_iaq=0 (operand, argument or data access) is translated with the data segment.
- R6: When cfg_we=1, cfg_sel=1 loads cfg_wdata into the code segment and cfg_sel=0 loads it into the data segment. The other segment is unchanged. When cfg_we=0, both segments keep their values whatever cfg_sel and cfg_wdata carry.
- R7: A request in the same clock as a segment write is translated with the segment value from before the write. Requests in later clocks use the new value.
- R8: phys_valid is 1 in the cycle after a clock where bus_req=1, and 0 in the cycle after a clock where bus_req=0.
- R9: After a clock with bus_req=0, phys_addr keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment write strobe |
| cfg_sel | input | 1 | Write target: 1 = code segment, 0 = data segment |
| cfg_wdata | input | 16 | Segment value to load |
| bus_req | input | 1 | Bus request in this cycle |
| bus_iaq | input | 1 | 1 = request is an opcode fetch |
| bus_laddr | input | 16 | Logical address of the request |
| phys_valid | output | 1 | phys_addr holds a new result |
| phys_addr | output | 20 | Translated physical address |

## Verification
A segment write and a bus request can land in the same clock. Translation must then use the value from before the write, and the following request must use the new one. The bench provokes this by writing the data segment while it issues a data-side request, and by writing the code segment under an opcode fetch. Write strobes also fall at random alongside random requests. Its scoreboard computes the expected address from a segment model that it updates only after the request's expectation has been queued, so a design that forwards the new value early produces a mismatch.

// File: rtl/seg_pkg.sv
package seg_pkg;

   typedef enum logic {
      SEG_DATA = 1'b0,
      SEG_CODE = 1'b1
   } seg_kind_e;

   function automatic int unsigned seg_max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  seg_kind_e        sel,
   input  logic [SEG_W-1:0] wdata,
   output logic [SEG_W-1:0] code_o,
   output logic [SEG_W-1:0] data_o
);

   localparam int unsigned NUM_SEG = 2;

   if (SEG_W < 1) begin : g_bad_width
      $error("seg_regfile: SEG_W must be at least 1");
   end

   logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q <= '0;
      end else begin
         for (int k = 0; k < NUM_SEG; k++) begin
            if (we && (sel == seg_kind_e'(k))) begin
               seg_q[k] <= wdata;
            end
         end
      end
   end

   assign code_o = seg_q[SEG_CODE];
   assign data_o = seg_q[SEG_DATA];

   p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(code_o) && $stable(data_o)));

   p_code_wr_spares_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEG_CODE) |=> $stable(data_o));

   p_data_wr_spares_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEG_DATA) |=> $stable(code_o));

   p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((($past(sel) == SEG_CODE) ? code_o : data_o) == $past(wdata)));

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic             iaq,
   input  logic [SEG_W-1:0] code_i,
   input  logic [SEG_W-1:0] data_i,
   output logic [SEG_W-1:0] seg_o
);

   seg_kind_e kind;

   // Opcode fetches take the code segment (R4); all else takes data (R5).
   always_comb begin
      kind  = iaq ? SEG_CODE : SEG_DATA;
      seg_o = (kind == SEG_CODE) ? code_i : data_i;
   end

endmodule

// File: rtl/seg_adder.sv
module seg_adder
   import seg_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned LOG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned PHYS_W    = 20,
   parameter bit          SPLIT_LOW = 1'b1
) (
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [LOG_W-1:0]  laddr_i,
   output logic [PHYS_W-1:0] phys_o
);

   localparam int unsigned SUM_W = seg_max3(SEG_W + SEG_SHIFT, LOG_W, PHYS_W) + 1;
   localparam int unsigned UP_W  = PHYS_W - SEG_SHIFT;

   if (SEG_SHIFT == 0 || SEG_SHIFT >= LOG_W) begin : g_bad_shift
      $error("seg_adder: SEG_SHIFT must lie between 1 and LOG_W-1");
   end
   if (PHYS_W <= SEG_SHIFT || PHYS_W < LOG_W) begin : g_bad_phys
      $error("seg_adder: PHYS_W too small for LOG_W and SEG_SHIFT");
   end

   if (SPLIT_LOW) begin : g_split
      // Low bits never receive a segment contribution: only the upper slice adds.
      logic [UP_W-1:0] upper;
      always_comb begin
         upper  = UP_W'(seg_i) + UP_W'(laddr_i >> SEG_SHIFT);
         phys_o = {upper, laddr_i[SEG_SHIFT-1:0]};
      end
   end else begin : g_full
      logic [SUM_W-1:0] shifted;
      logic [SUM_W-1:0] sum;
      always_comb begin
         shifted = SUM_W'(seg_i) << SEG_SHIFT;
         sum     = shifted + SUM_W'(laddr_i);
         phys_o  = sum[PHYS_W-1:0];
      end
   end

endmodule

// File: rtl/seg_addr_ext.sv
module seg_addr_ext
   import seg_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned LOG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned PHYS_W    = 20,
   parameter bit          SPLIT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [SEG_W-1:0]  cfg_wdata,
   input  logic              bus_req,
   input  logic              bus_iaq,
   input  logic [LOG_W-1:0]  bus_laddr,
   output logic              phys_valid,
   output logic [PHYS_W-1:0] phys_addr
);

   if (PHYS_W > SEG_W + SEG_SHIFT + 1) begin : g_wide_phys
      $error("seg_addr_ext: PHYS_W wider than the sum can fill");
   end

   logic [SEG_W-1:0]  code_seg;
   logic [SEG_W-1:0]  data_seg;
   logic [SEG_W-1:0]  cur_seg;
   logic [PHYS_W-1:0] phys_d;
   logic              valid_q;
   logic [PHYS_W-1:0] phys_q;

   seg_regfile #(.SEG_W(SEG_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (seg_kind_e'(cfg_sel)),
      .wdata  (cfg_wdata),
      .code_o (code_seg),
      .data_o (data_seg)
   );

   seg_select #(.SEG_W(SEG_W)) u_sel (
      .iaq    (bus_iaq),
      .code_i (code_seg),
      .data_i (data_seg),
      .seg_o  (cur_seg)
   );

   seg_adder #(
      .SEG_W     (SEG_W),
      .LOG_W     (LOG_W),
      .SEG_SHIFT (SEG_SHIFT),
      .PHYS_W    (PHYS_W),
      .SPLIT_LOW (SPLIT_LOW)
   ) u_add (
      .seg_i   (cur_seg),
      .laddr_i (bus_laddr),
      .phys_o  (phys_d)
   );

   // Segment registers feed the adder directly, so a write in this clock
   // lands only after the edge (R7).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         phys_q  <= '0;
      end else begin
         valid_q <= bus_req;
         if (bus_req) begin
            phys_q <= phys_d;
         end
      end
   end

   assign phys_valid = valid_q;
   assign phys_addr  = phys_q;

   p_valid_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> phys_valid);

   p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !phys_valid);

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> $stable(phys_addr));

   p_low_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> (phys_addr[SEG_SHIFT-1:0] == $past(bus_laddr[SEG_SHIFT-1:0])));

endmodule

// File: tb/sim_seg_addr_ext.sv
module sim_seg_addr_ext;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic        cfg_sel;
   logic [15:0] cfg_wdata;
   logic        bus_req;
   logic        bus_iaq;
   logic [15:0] bus_laddr;
   logic        phys_valid;
   logic [19:0] phys_addr;

   int n_checks = 0;
   int n_fail   = 0;

   logic [19:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] m_code = '0;
   logic [15:0] m_data = '0;
   logic [19:0] last_addr = '0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   seg_addr_ext u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .bus_req    (bus_req),
      .bus_iaq    (bus_iaq),
      .bus_laddr  (bus_laddr),
      .phys_valid (phys_valid),
      .phys_addr  (phys_addr)
   );

   function automatic logic [19:0] xlate(logic [15:0] s, logic [15:0] l);
      logic [20:0] t;
      t = {1'b0, s, 4'h0} + {5'h0, l};
      return t[19:0];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // One clock of stimulus; the expectation uses the segments before any write.
   task automatic cycle(bit req, bit iaq, logic [15:0] la, bit we, bit sel,
                        logic [15:0] wd, string tag);
      @(negedge clk);
      bus_req   = req;
      bus_iaq   = iaq;
      bus_laddr = la;
      cfg_we    = we;
      cfg_sel   = sel;
      cfg_wdata = wd;
      if (req) begin
         exp_q.push_back(xlate(iaq ? m_code : m_data, la));
         tag_q.push_back(tag);
      end
      if (we) begin
         if (sel) m_code = wd;
         else     m_data = wd;
      end
   endtask

   task automatic idle(bit we = 0, bit sel = 0, logic [15:0] wd = 16'h0);
      cycle(0, 0, 16'hDEAD, we, sel, wd, "");
   endtask

   // Monitor: looks one time unit after each edge.
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (phys_valid) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected valid", 32'(phys_valid), 32'd0);
            end else begin
               automatic logic [19:0] e = exp_q.pop_front();
               automatic string       t = tag_q.pop_front();
               check(t, 32'(phys_addr), 32'(e));
            end
            last_addr = phys_addr;
         end else begin
            check("R8 valid missing", 32'(exp_q.size()), 32'd0);
            check("R9 hold", 32'(phys_addr), 32'(last_addr));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
      bus_req = 1'b1; bus_iaq = 1'b1; bus_laddr = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset valid", 32'(phys_valid), 32'd0);
      check("R1 reset addr", 32'(phys_addr), 32'd0);
      @(negedge clk);
      bus_req = 0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 first cycle valid", 32'(phys_valid), 32'd0);
      check("R1 first cycle addr", 32'(phys_addr), 32'd0);

      cycle(1, 0, 16'h1234, 0, 0, 0, "R1 zero data segment");
      cycle(1, 1, 16'hBEEF, 0, 0, 0, "R1 zero code segment");
      idle();

      idle(1, 0, 16'h3120);
      idle(1, 1, 16'h0100);
      cycle(1, 0, 16'hA000, 0, 0, 0, "R2 R5 example 3120:A000");
      cycle(1, 1, 16'hA000, 0, 0, 0, "R4 code segment");
      cycle(1, 0, 16'h000F, 0, 0, 0, "R5 operand after opcode");
      cycle(1, 0, 16'h0002, 0, 0, 0, "R5 second operand");
      cycle(1, 1, 16'h0104, 0, 0, 0, "R4 next opcode");
      idle(); idle();

      cycle(1, 0, 16'h0000, 0, 1, 16'h7777, "R6 idle strobe ignored");
      idle(0, 1, 16'h5555);
      cycle(1, 1, 16'h0000, 0, 0, 0, "R6 code untouched by idle strobe");
      idle(1, 1, 16'h8000);
      cycle(1, 0, 16'h0010, 0, 0, 0, "R6 data spared by code write");
      cycle(1, 1, 16'h0010, 0, 0, 0, "R6 code loaded");

      idle(1, 0, 16'hFFFF);
      cycle(1, 0, 16'hFFFF, 0, 0, 0, "R3 wrap FFFF:FFFF");
      cycle(1, 0, 16'h0010, 0, 0, 0, "R3 wrap to zero");
      cycle(1, 1, 16'hFFFF, 0, 0, 0, "R3 code side no wrap");

      cycle(1, 0, 16'h0010, 1, 0, 16'h2000, "R7 write in same cycle uses old");
      cycle(1, 0, 16'h0010, 0, 0, 0, "R7 next cycle uses new");
      cycle(1, 1, 16'h0020, 1, 1, 16'h0ABC, "R7 code write under opcode fetch");
      cycle(1, 1, 16'h0020, 0, 0, 0, "R7 code new value");
      idle();

      for (int i = 0; i < 400; i++) begin
         automatic bit          rq = 1'($urandom_range(0, 3) != 0);
         automatic bit          iq = 1'($urandom);
         automatic bit          w  = 1'($urandom_range(0, 4) == 0);
         automatic bit          s  = 1'($urandom);
         automatic logic [15:0] la = 16'($urandom);
         automatic logic [15:0] wd = 16'($urandom);
         cycle(rq, iq, la, w, s, wd, "R2 R4 R5 R7 random");
      end
      idle(); idle();
      @(posedge clk); #2;
      done = 1'b1;
      check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule